// File: doc/BRIEF.md
# Dual Periodic Tick Generator

This block produces two independent periodic interrupt requests from one shared prescaled time base. A two-bit source field picks what advances the shared prescaler. The choices are every system clock cycle, one system cycle in four, or a strobe from a slow sub-clock. All sources are enable strobes in the single `clk` domain, so switching the source cannot glitch a clock.

The shared prescaler wraps every 2^PRE_W selected ticks. Each of the two channels counts those wraps and taps the count at its own ratio. A ratio code n gives one request every 2^(PRE_W+n) selected ticks. A request is a one-cycle pulse, meant to set a pending flag in an interrupt controller.

Writing a new ratio code restarts that channel's period on the prescaler grid. It never produces a stray request.

Top module: `tbase_dual_gen`

## Requirements
- R1: With `src_sel_i` = 2'b00 the prescaler advances every cycle, so after reset release a channel with ratio code n first pulses on the 2^(PRE_W+n)-th rising edge.
- R2: With `src_sel_i` = 2'b01 the prescaler advances on every fourth cycle, the first advance being the 4th edge after reset, giving a first pulse on edge 4*2^(PRE_W+n).
- R3: With `src_sel_i` = 2'b10 the prescaler advances only on cycles where `sub_tick_i` is high; with no strobes no pulse ever appears.
- R4: The code `src_sel_i` = 2'b11 behaves exactly as 2'b10.
- R5: Each channel has its own 3-bit ratio code n (0 to 7) selecting a period of 2^(PRE_W+n) selected ticks, with bit 0 of `tb_pulse_o` belonging to `ratio0_i` and bit 1 to `ratio1_i`.
- R6: Each request is high for exactly one cycle and repeats with a constant period, the second pulse falling at twice the edge count of the first.
- R7: While `rst` is high both pulses stay low, and reset clears all counters so the next period starts from zero.
- R8: When a channel's ratio code differs from the previous cycle, that channel emits no pulse in the following cycle and its wrap count restarts from zero.
- R9: A ratio change on one channel leaves the other channel's pulse timing unchanged.
- R10: When the sub-clock is not selected, `sub_tick_i` has no effect on pulse timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| src_sel_i | input | 2 | Prescaler source: 00 every cycle, 01 one cycle in four, 10/11 sub-clock strobe |
| sub_tick_i | input | 1 | One-cycle strobe from the slow sub-clock domain, already synchronized |
| ratio0_i | input | RATIO_W | Ratio code of channel 0 |
| ratio1_i | input | RATIO_W | Ratio code of channel 1 |
| tb_pulse_o | output | 2 | One-cycle request per channel period, bit c for channel c |

## Verification
The bench builds the block with PRE_W = 4 and leaves the ratio width at 3. This cuts the base period to 16 ticks, so the longest code 7 on the divide-by-four source is 8192 cycles. Every ratio code and every source code can then be run to a second pulse in a short run. The small base also places ratio changes both between prescaler wraps and exactly on a wrap, so the restart and suppression cases show up as distinct edge numbers.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;

    // Prescaler source codes; the top code aliases the sub-clock.
    typedef enum logic [1:0] {
        SRC_SYS     = 2'b00,
        SRC_QUARTER = 2'b01,
        SRC_SUB     = 2'b10,
        SRC_SUB_ALT = 2'b11
    } tb_src_e;

    // Candidate advance strobes, all in the single clock domain.
    typedef struct packed {
        logic sys;
        logic quarter;
        logic sub;
    } tb_strobes_t;

    function automatic logic pick_tick(tb_src_e sel, tb_strobes_t st);
        case (sel)
            SRC_SYS:     return st.sys;
            SRC_QUARTER: return st.quarter;
            default:     return st.sub;
        endcase
    endfunction

endpackage

// File: rtl/tbase_src_sel.sv
`timescale 1ns/1ps
module tbase_src_sel
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_i,
    input  logic       sub_tick_i,
    output logic       tick_o
);

    localparam int QW = 2;

    logic [QW-1:0] qcnt;
    tb_strobes_t   strobes;

    always_ff @(posedge clk) begin
        if (rst) qcnt <= '0;
        else     qcnt <= qcnt + QW'(1);
    end

    always_comb begin
        strobes.sys     = 1'b1;
        strobes.quarter = (qcnt == {QW{1'b1}});
        strobes.sub     = sub_tick_i;
        tick_o          = pick_tick(tb_src_e'(sel_i), strobes);
    end

    // R2: the divide-by-four strobe never stands two cycles in a row
    a_r2_quarter_spacing: assert property (@(posedge clk) disable iff (rst)
        strobes.quarter |=> !strobes.quarter);

endmodule

// File: rtl/tbase_prescaler.sv
`timescale 1ns/1ps
module tbase_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic wrap_o
);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (tick_i) cnt <= cnt + PRE_W'(1);
    end

    assign wrap_o = tick_i && (cnt == {PRE_W{1'b1}});

    // R1: each selected tick advances the shared count by one
    a_r1_prescale_step: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> cnt == $past(cnt) + PRE_W'(1));

    // R10: without a selected tick the shared count holds
    a_r10_prescale_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt));

endmodule

// File: rtl/tbase_channel.sv
`timescale 1ns/1ps
module tbase_channel #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               pulse_o
);

    localparam int EXT_W = (1 << RATIO_W) - 1;
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    logic [RATIO_W-1:0] ratio_q;
    logic [EXT_W-1:0]   ext;
    logic [EXT_W-1:0]   mask;
    logic               chg;
    logic               hit;
    logic               pulse_q;

    always_comb begin
        chg  = (ratio_i != ratio_q);
        mask = (ONE << ratio_i) - ONE;
        hit  = wrap_i && ((ext & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= ratio_i;
            ext     <= '0;
            pulse_q <= 1'b0;
        end else begin
            ratio_q <= ratio_i;
            pulse_q <= hit && !chg;
            if (chg)         ext <= '0;
            else if (wrap_i) ext <= ext + ONE;
        end
    end

    assign pulse_o = pulse_q;

    // R6: a request lasts exactly one cycle
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // R8: a freshly written ratio never produces a request next cycle
    a_r8_no_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
        (ratio_i != $past(ratio_i)) |=> !pulse_o);

endmodule

// File: rtl/tbase_dual_gen.sv
`timescale 1ns/1ps
module tbase_dual_gen #(
    parameter int PRE_W   = 8,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         src_sel_i,
    input  logic               sub_tick_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    output logic [1:0]         tb_pulse_o
);

    localparam int N_CH = 2;

    logic               sel_tick;
    logic               base_wrap;
    logic [RATIO_W-1:0] ratio_a [N_CH];

    assign ratio_a[0] = ratio0_i;
    assign ratio_a[1] = ratio1_i;

    tbase_src_sel u_src (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (src_sel_i),
        .sub_tick_i (sub_tick_i),
        .tick_o     (sel_tick)
    );

    tbase_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (sel_tick),
        .wrap_o (base_wrap)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tbase_channel #(.RATIO_W(RATIO_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wrap_i  (base_wrap),
            .ratio_i (ratio_a[c]),
            .pulse_o (tb_pulse_o[c])
        );
    end

    // R7: the cycle after a reset edge shows no request
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> tb_pulse_o == 2'b00);

    // R5: a request only follows a prescaler wrap
    a_r5_pulse_after_wrap: assert property (@(posedge clk) disable iff (rst)
        !base_wrap |=> tb_pulse_o == 2'b00);

endmodule

// File: tb/tbase_dual_gen_bench.sv
`timescale 1ns/1ps
module tbase_dual_gen_bench;

    localparam int PRE_W = 4;
    localparam int RW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    src_sel = 2'b00;
    logic          sub_tick = 1'b0;
    logic [RW-1:0] ratio0 = '0;
    logic [RW-1:0] ratio1 = '0;
    logic [1:0]    tb_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    int c0, c1;
    int e0 [8];
    int e1 [8];

    always #2 clk = ~clk;

    tbase_dual_gen #(.PRE_W(PRE_W), .RATIO_W(RW)) u_tbase_dual_gen (
        .clk        (clk),
        .rst        (rst),
        .src_sel_i  (src_sel),
        .sub_tick_i (sub_tick),
        .ratio0_i   (ratio0),
        .ratio1_i   (ratio1),
        .tb_pulse_o (tb_pulse)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic [2:0] r0;
        logic [2:0] r1;
        int         e0;
        int         e1;
    } vec_t;

    // expected first-pulse edge numbers with a 16-tick base, sub strobe every 8 cycles
    localparam vec_t VECS [6] = '{
        '{2'd0, 3'd0, 3'd1,   16,   32},
        '{2'd0, 3'd7, 3'd3, 2048,  128},
        '{2'd1, 3'd0, 3'd2,   64,  256},
        '{2'd1, 3'd5, 3'd7, 2048, 8192},
        '{2'd2, 3'd0, 3'd1,  128,  256},
        '{2'd3, 3'd2, 3'd0,  512,  128}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reset, then run nedges rising edges recording pulse edge numbers
    task automatic run_seq(input logic [1:0] sel, input logic [2:0] r0, input logic [2:0] r1,
                           input int nedges, input int chg_at,
                           input logic [2:0] r0_new, input logic [2:0] r1_new,
                           input bit sub_en);
        @(negedge clk);
        rst = 1'b1;
        src_sel = sel;
        ratio0 = r0;
        ratio1 = r1;
        sub_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        c0 = 0;
        c1 = 0;
        for (int k = 0; k < 8; k++) begin
            e0[k] = 0;
            e1[k] = 0;
        end
        for (int n = 1; n <= nedges; n++) begin
            sub_tick = sub_en && (n % 8 == 0);
            if (n == chg_at) begin
                ratio0 = r0_new;
                ratio1 = r1_new;
            end
            @(posedge clk);
            @(negedge clk);
            if (tb_pulse[0]) begin
                if (c0 < 8) e0[c0] = n;
                c0++;
            end
            if (tb_pulse[1]) begin
                if (c1 < 8) e1[c1] = n;
                c1++;
            end
        end
        sub_tick = 1'b0;
    endtask

    initial begin
        #(150000 * 4);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        string tag;
        int    len;
        // R7: no requests while reset is held, even with sources running
        rst = 1'b1;
        for (int n = 0; n < 20; n++) begin
            sub_tick = (n % 3 == 0);
            @(negedge clk);
            if (tb_pulse != 2'b00) chk(1'b0, "R7", int'(tb_pulse), 0);
        end
        chk(tb_pulse == 2'b00, "R7", int'(tb_pulse), 0);

        // table walk: sources and ratio codes
        for (int v = 0; v < 6; v++) begin
            len = 2 * ((VECS[v].e0 > VECS[v].e1) ? VECS[v].e0 : VECS[v].e1) + 2;
            run_seq(VECS[v].sel, VECS[v].r0, VECS[v].r1, len, 0, 3'd0, 3'd0, 1'b1);
            case (VECS[v].sel)
                2'd0:    tag = "R1";
                2'd1:    tag = "R2";
                2'd2:    tag = "R3";
                default: tag = "R4";
            endcase
            chk(e0[0] == VECS[v].e0, tag, e0[0], VECS[v].e0);
            chk(e1[0] == VECS[v].e1, "R5", e1[0], VECS[v].e1);
            chk(e0[1] == 2 * VECS[v].e0, "R6", e0[1], 2 * VECS[v].e0);
            chk(e1[1] == 2 * VECS[v].e1, "R6", e1[1], 2 * VECS[v].e1);
            if (VECS[v].sel < 2'd2)
                chk(c0 == len / VECS[v].e0, "R10", c0, len / VECS[v].e0);
        end

        // R3: sub-clock selected but silent gives no requests
        run_seq(2'd2, 3'd0, 3'd0, 300, 0, 3'd0, 3'd0, 1'b0);
        chk(c0 + c1 == 0, "R3", c0 + c1, 0);

        // R7: reset mid-period restarts the count from zero
        run_seq(2'd0, 3'd0, 3'd0, 10, 0, 3'd0, 3'd0, 1'b0);
        run_seq(2'd0, 3'd0, 3'd0, 20, 0, 3'd0, 3'd0, 1'b0);
        chk(e0[0] == 16, "R7", e0[0], 16);

        // R8: ratio 0 -> 2 between wraps restarts the count; R9: channel 1 untouched
        run_seq(2'd0, 3'd0, 3'd1, 100, 41, 3'd2, 3'd1, 1'b0);
        chk(c0 == 3, "R8", c0, 3);
        chk(e0[2] == 96, "R8", e0[2], 96);
        chk(c1 == 3, "R9", c1, 3);
        chk(e1[1] == 64, "R9", e1[1], 64);

        // R8: ratio 0 -> 1 on the very wrap edge that would hit is suppressed
        run_seq(2'd0, 3'd0, 3'd1, 100, 64, 3'd1, 3'd1, 1'b0);
        chk(c0 == 4, "R8", c0, 4);
        chk(e0[2] == 48, "R8", e0[2], 48);
        chk(e0[3] == 96, "R8", e0[3], 96);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule